// File: doc/BRIEF.md
# Dual-Port Banked Shared Memory Bridge

This block lets two independent bus masters, a host processor and a local microcontroller, exchange data through one common 8 KB byte-wide memory and four shared mailbox bytes. Each master sees the memory through its own 1 KB window. A private 3-bit bank register picks which 1 KB slice of the store that window shows. Because the two bank registers are separate, each side can look at a different slice at the same time, while the stored bytes stay common to both.

The host uses an 11-bit byte address with a chip select, a read/write level and an acknowledge output. The lower half of its space is the memory window. The upper half is a register area. In that area the mailbox bytes repeat every four addresses, and one write address loads the bank register. The microcontroller decodes the same layout at a fixed place in its 16-bit space and ignores every address outside it. Both ports run on one clock. A read returns its data one cycle after the access is presented. When both sides write the same byte in one cycle, the microcontroller's value is stored.

Top module: `shared_bank_bridge`

## Requirements
- R1: A host access at an address in 0x000–0x3FF reaches memory byte (host bank × 0x400) + address[9:0].
- R2: A host write to exactly 0x600 loads the host bank register from write-data bits [2:0]. The upper data bits are ignored, and no mailbox byte changes.
- R3: A host read anywhere in 0x400–0x5FF returns the mailbox byte selected by address[1:0], so the four bytes repeat across that range.
- R4: A host read anywhere in 0x600–0x7FF returns 0x00. The bank register cannot be read back.
- R5: A host write anywhere in 0x400–0x7FF, except exactly 0x600, stores into the mailbox byte selected by address[1:0].
- R6: The microcontroller reaches the memory window at 0x1000–0x13FF and the register area at 0x1400–0x17FF. The register area follows the same rules as R2–R5, with the bank load at 0x1600.
- R7: The microcontroller bank register is separate from the host bank register. Memory bytes and mailbox bytes written by either side are visible to the other side.
- R8: Reset clears both bank registers to 0 and all four mailbox bytes to 0x00, and it holds the acknowledge and both read-data outputs at 0.
- R9: Chip select presented in a cycle drives the host acknowledge to 1 in the next cycle, for reads and writes in every region. With no chip select, the acknowledge is 0 in the next cycle. Read data is valid in the cycle the acknowledge is high.
- R10: If both sides write the same memory byte or the same mailbox byte in one cycle, the microcontroller value is kept. A read that coincides with a write to the same byte returns the earlier value.
- R11: Microcontroller accesses outside 0x1000–0x17FF change nothing, and reads there return 0x00.
- R12: In the cycle after any cycle in which a port issued no read, that port's read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Asynchronous reset, active low |
| hostCs | input | 1 | Host chip select |
| hostRw | input | 1 | Host direction: 1 read, 0 write |
| hostAddr | input | 11 | Host byte address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data, registered |
| hostAck | output | 1 | Host data acknowledge, registered |
| mcuAddr | input | 16 | Microcontroller byte address |
| mcuRd | input | 1 | Microcontroller read strobe |
| mcuWr | input | 1 | Microcontroller write strobe |
| mcuWrData | input | 8 | Microcontroller write data |
| mcuRdData | output | 8 | Microcontroller read data, registered |

## Verification
The stimulus first sets the two bank registers to different values and reads bytes written by the opposite side. This shows whether the banks are truly private while the storage is common. Mailbox traffic uses mirrored addresses at the start and end of the register area. It also writes at high offsets other than 0x600, which separates mirroring from exact decoding of the bank-load address.

Both masters write the same memory byte and the same mailbox byte in the same cycle, which exposes a wrong write priority. A read that coincides with a write to the same byte checks that the read returns the earlier value. Writes to microcontroller addresses whose low bits alias the window or the mailbox show whether the upper address bits are decoded.

A reset in the middle of the run, issued after both banks and the mailbox have been changed, shows which state reset clears and which it leaves alone.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  // Per-port access strobes produced by the control decode.
  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic mbxRd;
    logic mbxWr;
    logic bankWr;
  } portStrobes_t;

  // Everything control hands to the datapath in one cycle.
  typedef struct packed {
    portStrobes_t host;
    portStrobes_t mcu;
  } ctrlStrobes_t;

  // Source that drives a port's read data in the cycle after an access.
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_RAM  = 2'd1,
    SEL_MBX  = 2'd2
  } rdSel_t;

endpackage

// File: rtl/sbb_port_decode.sv
module sbb_port_decode
  import sbb_pkg::*;
#(
  parameter int AW       = 16,
  parameter int WIN_AW   = 10,
  parameter int WIN_BASE = 32'h1000,
  parameter int REG_BASE = 32'h1400
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output portStrobes_t  stb
);

  localparam logic [AW-1:0]     WIN_B    = AW'(WIN_BASE);
  localparam logic [AW-1:0]     REG_B    = AW'(REG_BASE);
  localparam logic [WIN_AW-1:0] BANK_OFS = {1'b1, {(WIN_AW-1){1'b0}}};

  logic              inWin;
  logic              inReg;
  logic [WIN_AW-1:0] ofs;
  logic              upperHalf;
  logic              bankHit;

  // Both areas are aligned to their size, so a compare of the upper bits suffices.
  assign inWin     = addr[AW-1:WIN_AW] == WIN_B[AW-1:WIN_AW];
  assign inReg     = addr[AW-1:WIN_AW] == REG_B[AW-1:WIN_AW];
  assign ofs       = addr[WIN_AW-1:0];
  assign upperHalf = ofs[WIN_AW-1];
  assign bankHit   = ofs == BANK_OFS;

  always_comb begin
    stb        = '0;
    stb.ramRd  = rd && inWin;
    stb.ramWr  = wr && inWin;
    stb.mbxRd  = rd && inReg && !upperHalf;
    stb.mbxWr  = wr && inReg && !bankHit;
    stb.bankWr = wr && inReg && bankHit;
  end

endmodule

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
#(
  parameter int WIN_AW       = 10,
  parameter int MCU_AW       = 16,
  parameter int MCU_WIN_BASE = 32'h1000,
  parameter int MCU_REG_BASE = 32'h1400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs,
  input  logic              hostRw,
  input  logic [WIN_AW:0]   hostAddr,
  input  logic [MCU_AW-1:0] mcuAddr,
  input  logic              mcuRd,
  input  logic              mcuWr,
  output ctrlStrobes_t      stb,
  output logic              hostAck
);

  localparam int HOST_AW = WIN_AW + 1;

  logic hostRd;
  logic hostWr;

  assign hostRd = hostCs && hostRw;
  assign hostWr = hostCs && !hostRw;

  sbb_port_decode #(
    .AW      (HOST_AW),
    .WIN_AW  (WIN_AW),
    .WIN_BASE(0),
    .REG_BASE(1 << WIN_AW)
  ) hostDec_i (
    .addr(hostAddr),
    .rd  (hostRd),
    .wr  (hostWr),
    .stb (stb.host)
  );

  sbb_port_decode #(
    .AW      (MCU_AW),
    .WIN_AW  (WIN_AW),
    .WIN_BASE(MCU_WIN_BASE),
    .REG_BASE(MCU_REG_BASE)
  ) mcuDec_i (
    .addr(mcuAddr),
    .rd  (mcuRd),
    .wr  (mcuWr),
    .stb (stb.mcu)
  );

  // Acknowledge follows chip select by one cycle, matching the read-data register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostAck <= 1'b0;
    else       hostAck <= hostCs;
  end

endmodule

// File: rtl/sbb_datapath.sv
module sbb_datapath
  import sbb_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int WIN_AW = 10,
  parameter int DW     = 8,
  parameter int MBX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [WIN_AW-1:0] hostOfs,
  input  logic [WIN_AW-1:0] mcuOfs,
  input  logic [DW-1:0]     hostWrData,
  input  logic [DW-1:0]     mcuWrData,
  output logic [DW-1:0]     hostRdData,
  output logic [DW-1:0]     mcuRdData
);

  // Port 0 is the host, port 1 the microcontroller; a higher index wins write collisions.
  localparam int NP        = 2;
  localparam int RAM_AW    = BANK_W + WIN_AW;
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int MBX_N     = 1 << MBX_W;

  logic [DW-1:0]     ram [RAM_DEPTH];
  logic [DW-1:0]     mbx [MBX_N];

  portStrobes_t      pStb  [NP];
  logic [WIN_AW-1:0] pOfs  [NP];
  logic [DW-1:0]     pWr   [NP];
  logic [DW-1:0]     pRd   [NP];
  logic [RAM_AW-1:0] pPhys [NP];
  logic [MBX_W-1:0]  pIdx  [NP];

  assign pStb[0]    = stb.host;
  assign pStb[1]    = stb.mcu;
  assign pOfs[0]    = hostOfs;
  assign pOfs[1]    = mcuOfs;
  assign pWr[0]     = hostWrData;
  assign pWr[1]     = mcuWrData;
  assign hostRdData = pRd[0];
  assign mcuRdData  = pRd[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [BANK_W-1:0] bankQ;
    rdSel_t            rdSel;
    logic [DW-1:0]     ramQ;
    logic [DW-1:0]     mbxQ;

    assign pPhys[p] = {bankQ, pOfs[p]};
    assign pIdx[p]  = pOfs[p][MBX_W-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ <= '0;
        rdSel <= SEL_ZERO;
        mbxQ  <= '0;
      end else begin
        if (pStb[p].bankWr) bankQ <= pWr[p][BANK_W-1:0];
        if (pStb[p].ramRd)      rdSel <= SEL_RAM;
        else if (pStb[p].mbxRd) rdSel <= SEL_MBX;
        else                    rdSel <= SEL_ZERO;
        if (pStb[p].mbxRd) mbxQ <= mbx[pIdx[p]];
      end
    end

    // Memory read port: read-before-write against either write port.
    always_ff @(posedge clk) begin
      if (pStb[p].ramRd) ramQ <= ram[pPhys[p]];
    end

    always_comb begin
      unique case (rdSel)
        SEL_RAM: pRd[p] = ramQ;
        SEL_MBX: pRd[p] = mbxQ;
        default: pRd[p] = '0;
      endcase
    end
  end

  // Shared store: later ports overwrite earlier ones on the same byte.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (pStb[p].ramWr) ram[pPhys[p]] <= pWr[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MBX_N; i++) mbx[i] <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (pStb[p].mbxWr) mbx[pIdx[p]] <= pWr[p];
      end
    end
  end

endmodule

// File: rtl/shared_bank_bridge.sv
module shared_bank_bridge
  import sbb_pkg::*;
#(
  parameter int BANK_W       = 3,
  parameter int WIN_AW       = 10,
  parameter int DW           = 8,
  parameter int MBX_W        = 2,
  parameter int MCU_AW       = 16,
  parameter int MCU_WIN_BASE = 32'h1000,
  parameter int MCU_REG_BASE = 32'h1400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs,
  input  logic              hostRw,
  input  logic [WIN_AW:0]   hostAddr,
  input  logic [DW-1:0]     hostWrData,
  output logic [DW-1:0]     hostRdData,
  output logic              hostAck,
  input  logic [MCU_AW-1:0] mcuAddr,
  input  logic              mcuRd,
  input  logic              mcuWr,
  input  logic [DW-1:0]     mcuWrData,
  output logic [DW-1:0]     mcuRdData
);

  ctrlStrobes_t stb;

  sbb_ctrl #(
    .WIN_AW      (WIN_AW),
    .MCU_AW      (MCU_AW),
    .MCU_WIN_BASE(MCU_WIN_BASE),
    .MCU_REG_BASE(MCU_REG_BASE)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .hostCs  (hostCs),
    .hostRw  (hostRw),
    .hostAddr(hostAddr),
    .mcuAddr (mcuAddr),
    .mcuRd   (mcuRd),
    .mcuWr   (mcuWr),
    .stb     (stb),
    .hostAck (hostAck)
  );

  sbb_datapath #(
    .BANK_W(BANK_W),
    .WIN_AW(WIN_AW),
    .DW    (DW),
    .MBX_W (MBX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostOfs   (hostAddr[WIN_AW-1:0]),
    .mcuOfs    (mcuAddr[WIN_AW-1:0]),
    .hostWrData(hostWrData),
    .mcuWrData (mcuWrData),
    .hostRdData(hostRdData),
    .mcuRdData (mcuRdData)
  );

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostCs,
  input logic        hostRw,
  input logic [10:0] hostAddr,
  input logic [7:0]  hostWrData,
  input logic [7:0]  hostRdData,
  input logic        hostAck,
  input logic [15:0] mcuAddr,
  input logic        mcuRd,
  input logic        mcuWr,
  input logic [7:0]  mcuRdData
);

  logic hostMbxWr;
  logic mcuMbxWrSame;
  logic hostMbxRd;

  assign hostMbxWr    = hostCs && !hostRw && hostAddr[10] && hostAddr != 11'h600;
  assign mcuMbxWrSame = mcuWr && mcuAddr[15:10] == 6'b000101 && mcuAddr != 16'h1600
                        && mcuAddr[1:0] == hostAddr[1:0];
  assign hostMbxRd    = hostCs && hostRw && hostAddr[10:9] == 2'b10;

  AST_ACK_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    hostCs |=> hostAck);  // R9

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !hostCs |=> !hostAck);  // R9

  AST_HOST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostCs && hostRw && hostAddr[10:9] == 2'b11) |=> hostRdData == 8'h00);  // R4

  AST_MCU_OOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mcuRd && mcuAddr[15:11] != 5'b00010) |=> mcuRdData == 8'h00);  // R11

  AST_HOST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(hostCs && hostRw) |=> hostRdData == 8'h00);  // R12

  AST_MBX_WRITE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (hostMbxWr && !mcuMbxWrSame) ##1
    (hostMbxRd && hostAddr[1:0] == $past(hostAddr[1:0]))
    |=> hostRdData == $past(hostWrData, 2));  // R5

endmodule

bind shared_bank_bridge sbb_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .hostCs    (hostCs),
  .hostRw    (hostRw),
  .hostAddr  (hostAddr),
  .hostWrData(hostWrData),
  .hostRdData(hostRdData),
  .hostAck   (hostAck),
  .mcuAddr   (mcuAddr),
  .mcuRd     (mcuRd),
  .mcuWr     (mcuWr),
  .mcuRdData (mcuRdData)
);

// File: tb/shared_bank_bridge_tb.sv
module shared_bank_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCs = 1'b0;
  logic        hostRw = 1'b1;
  logic [10:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        hostAck;
  logic [15:0] mcuAddr = '0;
  logic        mcuRd = 1'b0;
  logic        mcuWr = 1'b0;
  logic [7:0]  mcuWrData = '0;
  logic [7:0]  mcuRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shared_bank_bridge dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostCs    (hostCs),
    .hostRw    (hostRw),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .hostAck   (hostAck),
    .mcuAddr   (mcuAddr),
    .mcuRd     (mcuRd),
    .mcuWr     (mcuWr),
    .mcuWrData (mcuWrData),
    .mcuRdData (mcuRdData)
  );

  // Operation codes: 0 idle, 1 read, 2 write.
  // Vector: {req[70:63], hOp[62:61], hAddr[60:50], hData[49:42],
  //          mOp[41:40], mAddr[39:24], mData[23:16], expHost[15:8], expMcu[7:0]}
  localparam int NV = 21;
  localparam logic [70:0] VEC [NV] = '{
    {8'd1,  2'd2, 11'h000, 8'hA5, 2'd0, 16'h0000, 8'h00, 8'h00, 8'h00}, // R1 bank 0 write
    {8'd2,  2'd2, 11'h600, 8'hFB, 2'd0, 16'h0000, 8'h00, 8'h00, 8'h00}, // R2 host bank = 3
    {8'd7,  2'd2, 11'h000, 8'h3C, 2'd1, 16'h1000, 8'h00, 8'h00, 8'hA5}, // R7 mcu bank 0
    {8'd1,  2'd1, 11'h000, 8'h00, 2'd2, 16'h1600, 8'h03, 8'h3C, 8'h00}, // R1 bank 3 read, R6 mcu bank
    {8'd7,  2'd2, 11'h600, 8'h00, 2'd1, 16'h1000, 8'h00, 8'h00, 8'h3C}, // R7 shared slice
    {8'd2,  2'd1, 11'h000, 8'h00, 2'd0, 16'h0000, 8'h00, 8'hA5, 8'h00}, // R2 host back on bank 0
    {8'd5,  2'd2, 11'h401, 8'h11, 2'd2, 16'h1402, 8'h22, 8'h00, 8'h00}, // R5 R6 mailbox writes
    {8'd3,  2'd1, 11'h5FE, 8'h00, 2'd1, 16'h1501, 8'h00, 8'h22, 8'h11}, // R3 mirror
    {8'd5,  2'd2, 11'h7FF, 8'h33, 2'd1, 16'h1603, 8'h00, 8'h00, 8'h00}, // R5 high write, R6 zero
    {8'd4,  2'd1, 11'h403, 8'h00, 2'd1, 16'h1600, 8'h00, 8'h33, 8'h00}, // R4 R6 bank unreadable
    {8'd4,  2'd1, 11'h600, 8'h00, 2'd2, 16'h1600, 8'h08, 8'h00, 8'h00}, // R4, mcu bank 0
    {8'd10, 2'd2, 11'h003, 8'h44, 2'd2, 16'h1003, 8'h55, 8'h00, 8'h00}, // R10 ram collision
    {8'd10, 2'd1, 11'h003, 8'h00, 2'd2, 16'hFFFF, 8'h99, 8'h55, 8'h00}, // R10 winner, R11 write
    {8'd10, 2'd2, 11'h402, 8'h66, 2'd2, 16'h1402, 8'h77, 8'h00, 8'h00}, // R10 mailbox collision
    {8'd11, 2'd1, 11'h402, 8'h00, 2'd1, 16'h1403, 8'h00, 8'h77, 8'h33}, // R11 mailbox untouched
    {8'd12, 2'd0, 11'h000, 8'h00, 2'd1, 16'h1003, 8'h00, 8'h00, 8'h55}, // R12 host idle
    {8'd11, 2'd1, 11'h400, 8'h00, 2'd1, 16'h0402, 8'h00, 8'h00, 8'h00}, // R11 alias read
    {8'd10, 2'd2, 11'h000, 8'hEE, 2'd1, 16'h1000, 8'h00, 8'h00, 8'hA5}, // R10 read old value
    {8'd7,  2'd0, 11'h000, 8'h00, 2'd1, 16'h1000, 8'h00, 8'h00, 8'hEE}, // R7 host write seen
    {8'd11, 2'd1, 11'h003, 8'h00, 2'd2, 16'h0003, 8'h77, 8'h55, 8'h00}, // R11 alias write
    {8'd11, 2'd1, 11'h003, 8'h00, 2'd0, 16'h0000, 8'h00, 8'h55, 8'h00}  // R11 ram untouched
  };

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Present one access pair for one cycle; outputs sampled at the next falling edge.
  task automatic step(input logic [1:0] hOp, input logic [10:0] hA, input logic [7:0] hD,
                      input logic [1:0] mOp, input logic [15:0] mA, input logic [7:0] mD);
    @(negedge clk);
    hostCs     = hOp != 2'd0;
    hostRw     = hOp != 2'd2;
    hostAddr   = hA;
    hostWrData = hD;
    mcuRd      = mOp == 2'd1;
    mcuWr      = mOp == 2'd2;
    mcuAddr    = mA;
    mcuWrData  = mD;
    @(negedge clk);
    hostCs = 1'b0;
    mcuRd  = 1'b0;
    mcuWr  = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    string rq;
    // R8: outputs during reset
    repeat (3) @(negedge clk);
    check("R8", "ack in reset", {7'd0, hostAck}, 8'h00);
    check("R8", "host data in reset", hostRdData, 8'h00);
    rstN = 1'b1;

    // R8: mailbox cleared after reset
    for (int i = 0; i < 4; i++) begin
      step(2'd1, 11'h400 + 11'(i), 8'h00, 2'd1, 16'h1400 + 16'(i), 8'h00);
      check("R8", "host mailbox after reset", hostRdData, 8'h00);
      check("R8", "mcu mailbox after reset", mcuRdData, 8'h00);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [70:0] e;
      e = VEC[v];
      rq = $sformatf("R%0d", e[70:63]);
      step(e[62:61], e[60:50], e[49:42], e[41:40], e[39:24], e[23:16]);
      check(rq, "host read data", hostRdData, e[62:61] == 2'd1 ? e[15:8] : 8'h00);
      check("R9", "host ack", {7'd0, hostAck}, {7'd0, e[62:61] != 2'd0});
      check(rq, "mcu read data", mcuRdData, e[41:40] == 2'd1 ? e[7:0] : 8'h00);
    end

    // R9: ack drops in the cycle after chip select goes away
    @(negedge clk);
    check("R9", "ack after idle", {7'd0, hostAck}, 8'h00);

    // R8: reset after both banks moved returns them to 0, mailbox cleared
    step(2'd2, 11'h600, 8'h05, 2'd2, 16'h1600, 8'h06);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    step(2'd1, 11'h401, 8'h00, 2'd1, 16'h1402, 8'h00);
    check("R8", "host mailbox cleared", hostRdData, 8'h00);
    check("R8", "mcu mailbox cleared", mcuRdData, 8'h00);
    step(2'd1, 11'h000, 8'h00, 2'd1, 16'h1003, 8'h00);
    check("R8", "host bank 0 after reset", hostRdData, 8'hEE);
    check("R8", "mcu bank 0 after reset", mcuRdData, 8'h55);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule